// File: doc/BRIEF.md
# Parallel Adapter Bus Register File and Transfer Counter

This block is the host-bus side register set of a parallel word-transfer adapter that sits between a processor bus and an external device. The bus addresses registers by a 4-bit number, and the meaning of an address differs between reads and writes. The block holds a 24-bit transfer counter split across two addresses, the handshake mode and flag polarity, the user control lines, the option enables that lend two control lines and two status lines to handshake and attention signals, and the interrupt request raised by the external attention line.

The buffer data path and the handshake sequencer sit outside the block. Their flags and line levels come in on inputs. The sequencer pulses one input for each word moved, which counts the transfer counter down. A read of the acknowledge address returns a constant and clears the pending interrupt request. A packed status word gives software one view of the buffer flags, handshake lines, latched end and attention events, and the status lines.

Read data is combinational from the current state while the read strobe is high. Side effects of a read or a write take hold at the rising clock edge that ends the access.

Top module: `fifo_adapter_regs`

## Requirements
- R1: After reset the counter is 0 and zero is asserted, the mode is 0, flag polarity is active-high, the handshake-option enable is 1, end recognition is off, the interrupt enable and request are 0, the device enable is 0 and all user control bits are 0.
- R2: A write to address 0xA loads counter bits [15:0] from the data. A write to address 0xB loads counter bits [23:16] from data [15:8]. A read of 0xA returns counter [15:0]. A read of 0xB returns counter [23:16] in bits [15:8] and zero in bits [7:0].
- R3: Each transfer pulse decrements a nonzero counter by one. At 0 the counter holds at 0, and `cnt_zero` is high exactly when the counter is 0.
- R4: A write to 0xB with data bit 5 set clears the whole counter in that cycle, overriding the high-byte data. Any counter write takes priority over a transfer pulse in the same cycle.
- R5: A 0xB write sets `hs_mode` from data [2:0]. Data bit 5 of a write to address 7 sets `pflg_low_true`.
- R6: A write to address 7 stores control bits 5,4,3 from data bits 10,9,8 and control bits 2..0 from data [2:0], and the handshake-option enable from data bit 6. While that enable is 1, `ctl_lines[5:4]` carry {`hs_pdir`,`hs_hend`}; otherwise they carry the stored bits. `ctl_lines[3:0]` always carry the stored bits.
- R7: While end recognition (address 7 write, data bit 7) is on, `sts_lines[4]` shows the synchronized `ext_pend`. While the interrupt enable is on, `sts_lines[5]` shows the synchronized `ext_attn`. Otherwise each line passes `ext_sts`.
- R8: A read of address 7 returns, from bit 15 down: half-full, almost-empty/full, latched end, synchronized attention, zero, status line 5, status line 4, `ext_sts[3]`, `hs_pctl`, `hs_pflg`, output-ready, input-ready, `hs_hend`, `ext_sts[2:0]`.
- R9: A read of address 1 returns 0 in [15:8], 5'b11001 in [7:3], the interrupt enable in bit 2, 0 in bit 1 and the request in bit 0. Writing address 1 with data bit 1 sets the enable and with bit 0 clears it (clear wins). Bit 4 sets `dev_enable`.
- R10: A rising synchronized `ext_attn` sets the interrupt request only while the interrupt enable is 1. The request then holds.
- R11: A read of address 9 returns 0x0010 and clears the request. Reads of other addresses leave it set.
- R12: A read of address 3 returns 0x0020 with the REVISION parameter in bits [10:8].
- R13: A rising synchronized `ext_pend` sets the latched end flag while recognition is on. A 0xB write with data bit 4 clears it. Writing address 7 with data bit 4 pulses `fifo_clear`, and writing address 1 with data bit 5 pulses `dev_clear`, each for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Register number |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| xfer_pulse | input | 1 | One word moved, from the sequencer |
| fifo_half | input | 1 | Buffer half-full flag |
| fifo_aef | input | 1 | Buffer almost-empty/full flag |
| fifo_or | input | 1 | Output-ready flag |
| fifo_ir | input | 1 | Input-ready flag |
| hs_pctl | input | 1 | Handshake control line level |
| hs_pflg | input | 1 | Handshake flag line level |
| hs_pdir | input | 1 | Transfer direction from the sequencer |
| hs_hend | input | 1 | Host end marker from the sequencer |
| ext_pend | input | 1 | Peripheral end line (asynchronous) |
| ext_attn | input | 1 | Attention line (asynchronous) |
| ext_sts | input | 6 | Peripheral status lines |
| ctl_lines | output | 6 | Control lines to the device |
| sts_lines | output | 6 | Status lines after option multiplexing |
| hs_mode | output | 3 | Handshake mode select |
| pflg_low_true | output | 1 | Flag polarity select |
| irq_req | output | 1 | Pending interrupt request |
| cnt_zero | output | 1 | Counter is zero |
| fifo_clear | output | 1 | One-cycle buffer clear pulse |
| dev_clear | output | 1 | One-cycle device clear pulse |
| dev_enable | output | 1 | Device enable |

## Verification
The bench builds the block with SYNC_STAGES = 3 and REVISION = 5. The deeper synchronizer makes the attention and end-line latency differ from the default, so wrong stage counting is caught. The nonzero revision makes the identification field visible in bits [10:8]. With these values, the interrupt request is checked as it rises, holds across unrelated reads and clears on the acknowledge read. They also bring within reach the counter's floor at zero, the same-cycle clear and write priority over a transfer pulse, and both positions of every option multiplexer.

// File: rtl/fifo_adapter_regs_pkg.sv
package fifo_adapter_regs_pkg;

  localparam int REG_W    = 16;
  localparam int CNT_W    = 24;
  localparam int CNT_LO_W = 16;
  localparam int CNT_HI_W = CNT_W - CNT_LO_W;
  localparam int LINES    = 6;

  localparam logic [3:0] ADR_SENSE  = 4'h1;
  localparam logic [3:0] ADR_IDENT  = 4'h3;
  localparam logic [3:0] ADR_STATUS = 4'h7;
  localparam logic [3:0] ADR_ACK    = 4'h9;
  localparam logic [3:0] ADR_CNT_LO = 4'hA;
  localparam logic [3:0] ADR_CNT_HI = 4'hB;

  localparam logic [4:0]       SENSE_TAG = 5'b11001;
  localparam logic [REG_W-1:0] ACK_WORD  = 16'h0010;

  typedef struct packed {
    logic       half;
    logic       aef;
    logic       pend_seen;
    logic       attn_lvl;
    logic       zero;
    logic       line5;
    logic       line4;
    logic       line3;
    logic       pctl;
    logic       pflg;
    logic       out_rdy;
    logic       in_rdy;
    logic       hend;
    logic [2:0] line_lo;
  } status_t;

  function automatic logic [REG_W-1:0] id_word(input logic [2:0] rev);
    id_word = {5'b00000, rev, 8'h20};
  endfunction

  function automatic logic [REG_W-1:0] sense_word(input logic en, input logic req);
    sense_word = {8'h00, SENSE_TAG, en, 1'b0, req};
  endfunction

  function automatic logic [REG_W-1:0] hi_word(input logic [CNT_HI_W-1:0] hi);
    hi_word = {hi, 8'h00};
  endfunction

endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter
  import fifo_adapter_regs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                ld_lo,
  input  logic [CNT_LO_W-1:0] lo_val,
  input  logic                ld_hi,
  input  logic [CNT_HI_W-1:0] hi_val,
  input  logic                dec,
  output logic [CNT_W-1:0]    count,
  output logic                zero
);
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    step_down = (c == '0) ? c : c - 1'b1;
  endfunction

  logic any_load;
  assign any_load = ld_lo | ld_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (any_load) begin
      if (ld_lo) count[CNT_LO_W-1:0]     <= lo_val;
      if (ld_hi) count[CNT_W-1:CNT_LO_W] <= hi_val;
    end else if (dec) begin
      count <= step_down(count);
    end
  end

  assign zero = (count == '0);

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !clr && !any_load && !zero) |=> (count == $past(count) - 1'b1));
  a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !any_load) |=> zero);
  a_r4_clear_now: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> zero);
  a_r4_write_beats_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lo && !clr) |=> (count[CNT_LO_W-1:0] == $past(lo_val)));
endmodule

// File: rtl/attn_irq.sv
module attn_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic attn_s,
  input  logic irq_en,
  input  logic ack_rd,
  output logic attn_rise,
  output logic arq
);
  logic attn_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) attn_prev <= 1'b0;
    else        attn_prev <= attn_s;
  end

  assign attn_rise = attn_s & ~attn_prev;

  // A new event in the acknowledge cycle wins, so no edge is lost.
  always_ff @(posedge clk) begin
    if (!rst_n)                   arq <= 1'b0;
    else if (attn_rise && irq_en) arq <= 1'b1;
    else if (ack_rd)              arq <= 1'b0;
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (arq && !ack_rd) |=> arq);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!arq && !(attn_rise && irq_en)) |=> !arq);
  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !(attn_rise && irq_en)) |=> !arq);
endmodule

// File: rtl/line_mux.sv
module line_mux
  import fifo_adapter_regs_pkg::*;
(
  input  logic [LINES-1:0] ctl_bits,
  input  logic             opt_en,
  input  logic             pdir,
  input  logic             hend,
  input  logic [LINES-1:0] ext_sts,
  input  logic             pend_rec,
  input  logic             pend_s,
  input  logic             irq_en,
  input  logic             attn_s,
  output logic [LINES-1:0] ctl_lines,
  output logic [LINES-1:0] sts_lines
);
  always_comb begin
    ctl_lines = ctl_bits;
    if (opt_en) ctl_lines[5:4] = {pdir, hend};
  end

  always_comb begin
    sts_lines = ext_sts;
    if (pend_rec) sts_lines[4] = pend_s;
    if (irq_en)   sts_lines[5] = attn_s;
  end
endmodule

// File: rtl/fifo_adapter_regs.sv
module fifo_adapter_regs
  import fifo_adapter_regs_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] REVISION    = 3'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [3:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             xfer_pulse,
  input  logic             fifo_half,
  input  logic             fifo_aef,
  input  logic             fifo_or,
  input  logic             fifo_ir,
  input  logic             hs_pctl,
  input  logic             hs_pflg,
  input  logic             hs_pdir,
  input  logic             hs_hend,
  input  logic             ext_pend,
  input  logic             ext_attn,
  input  logic [LINES-1:0] ext_sts,
  output logic [LINES-1:0] ctl_lines,
  output logic [LINES-1:0] sts_lines,
  output logic [2:0]       hs_mode,
  output logic             pflg_low_true,
  output logic             irq_req,
  output logic             cnt_zero,
  output logic             fifo_clear,
  output logic             dev_clear,
  output logic             dev_enable
);
  // Named access events, used by the logic and by the assertions.
  logic wr_sense, wr_status, wr_lo, wr_hi, ack_rd;
  assign wr_sense  = bus_wr && (bus_addr == ADR_SENSE);
  assign wr_status = bus_wr && (bus_addr == ADR_STATUS);
  assign wr_lo     = bus_wr && (bus_addr == ADR_CNT_LO);
  assign wr_hi     = bus_wr && (bus_addr == ADR_CNT_HI);
  assign ack_rd    = bus_rd && (bus_addr == ADR_ACK);

  logic cnt_clr, pend_rst;
  assign cnt_clr  = wr_hi && bus_wdata[5];
  assign pend_rst = wr_hi && bus_wdata[4];

  // Configuration state
  logic [LINES-1:0] ctl_bits;
  logic             opt_en, pend_rec, irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_bits      <= '0;
      opt_en        <= 1'b1;
      pend_rec      <= 1'b0;
      pflg_low_true <= 1'b0;
      fifo_clear    <= 1'b0;
    end else begin
      fifo_clear <= wr_status && bus_wdata[4];
      if (wr_status) begin
        ctl_bits      <= {bus_wdata[10:8], bus_wdata[2:0]};
        pend_rec      <= bus_wdata[7];
        opt_en        <= bus_wdata[6];
        pflg_low_true <= bus_wdata[5];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en     <= 1'b0;
      dev_enable <= 1'b0;
      dev_clear  <= 1'b0;
    end else begin
      dev_clear <= wr_sense && bus_wdata[5];
      if (wr_sense) begin
        dev_enable <= bus_wdata[4];
        if (bus_wdata[0])      irq_en <= 1'b0;
        else if (bus_wdata[1]) irq_en <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     hs_mode <= 3'd0;
    else if (wr_hi) hs_mode <= bus_wdata[2:0];
  end

  // Asynchronous line synchronization
  logic attn_s, pend_s;
  sig_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ext_attn, ext_pend}),
    .q    ({attn_s, pend_s})
  );

  // Latched peripheral end event
  logic pend_prev, pend_rise, pend_seen;
  assign pend_rise = pend_s & ~pend_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_prev <= 1'b0;
      pend_seen <= 1'b0;
    end else begin
      pend_prev <= pend_s;
      if (pend_rise && pend_rec) pend_seen <= 1'b1;
      else if (pend_rst)         pend_seen <= 1'b0;
    end
  end

  // Transfer counter
  logic [CNT_W-1:0] count;
  xfer_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .ld_lo (wr_lo),
    .lo_val(bus_wdata),
    .ld_hi (wr_hi),
    .hi_val(bus_wdata[15:8]),
    .dec   (xfer_pulse),
    .count (count),
    .zero  (cnt_zero)
  );

  // Interrupt request
  logic attn_rise;
  attn_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .attn_s   (attn_s),
    .irq_en   (irq_en),
    .ack_rd   (ack_rd),
    .attn_rise(attn_rise),
    .arq      (irq_req)
  );

  // Line multiplexing
  line_mux u_lines (
    .ctl_bits (ctl_bits),
    .opt_en   (opt_en),
    .pdir     (hs_pdir),
    .hend     (hs_hend),
    .ext_sts  (ext_sts),
    .pend_rec (pend_rec),
    .pend_s   (pend_s),
    .irq_en   (irq_en),
    .attn_s   (attn_s),
    .ctl_lines(ctl_lines),
    .sts_lines(sts_lines)
  );

  // Packed status word
  status_t st;
  always_comb begin
    st.half      = fifo_half;
    st.aef       = fifo_aef;
    st.pend_seen = pend_seen;
    st.attn_lvl  = attn_s;
    st.zero      = cnt_zero;
    st.line5     = sts_lines[5];
    st.line4     = sts_lines[4];
    st.line3     = ext_sts[3];
    st.pctl      = hs_pctl;
    st.pflg      = hs_pflg;
    st.out_rdy   = fifo_or;
    st.in_rdy    = fifo_ir;
    st.hend      = hs_hend;
    st.line_lo   = ext_sts[2:0];
  end

  // Read multiplexer
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADR_SENSE:  bus_rdata = sense_word(irq_en, irq_req);
        ADR_IDENT:  bus_rdata = id_word(REVISION);
        ADR_STATUS: bus_rdata = st;
        ADR_ACK:    bus_rdata = ACK_WORD;
        ADR_CNT_LO: bus_rdata = count[CNT_LO_W-1:0];
        ADR_CNT_HI: bus_rdata = hi_word(count[CNT_W-1:CNT_LO_W]);
        default:    bus_rdata = '0;
      endcase
    end
  end

  a_r2_hi_low_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADR_CNT_HI) |-> (bus_rdata[7:0] == 8'h00));
  a_r9_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sense && bus_wdata[0]) |=> !irq_en);
  a_r13_pend_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_rst && !(pend_rise && pend_rec)) |=> !pend_seen);
  a_r13_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |-> $past(wr_status && bus_wdata[4]));
  a_r5_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (hs_mode == $past(bus_wdata[2:0])));
endmodule

// File: tb/fifo_adapter_regs_test.sv
module fifo_adapter_regs_test;
  localparam int         SYNC = 3;
  localparam logic [2:0] REV  = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic xfer_pulse = 0;
  logic fifo_half = 0, fifo_aef = 0, fifo_or = 0, fifo_ir = 0;
  logic hs_pctl = 0, hs_pflg = 0, hs_pdir = 1, hs_hend = 0;
  logic ext_pend = 0, ext_attn = 0;
  logic [5:0] ext_sts = 6'b101010;
  logic [5:0] ctl_lines, sts_lines;
  logic [2:0] hs_mode;
  logic pflg_low_true, irq_req, cnt_zero, fifo_clear, dev_clear, dev_enable;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fifo_adapter_regs #(.SYNC_STAGES(SYNC), .REVISION(REV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_pulse(xfer_pulse), .fifo_half(fifo_half), .fifo_aef(fifo_aef),
    .fifo_or(fifo_or), .fifo_ir(fifo_ir), .hs_pctl(hs_pctl), .hs_pflg(hs_pflg),
    .hs_pdir(hs_pdir), .hs_hend(hs_hend), .ext_pend(ext_pend), .ext_attn(ext_attn),
    .ext_sts(ext_sts), .ctl_lines(ctl_lines), .sts_lines(sts_lines),
    .hs_mode(hs_mode), .pflg_low_true(pflg_low_true), .irq_req(irq_req),
    .cnt_zero(cnt_zero), .fifo_clear(fifo_clear), .dev_clear(dev_clear),
    .dev_enable(dev_enable)
  );

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic pulse_xfer();
    @(negedge clk); xfer_pulse = 1;
    @(negedge clk); xfer_pulse = 0;
  endtask

  task automatic settle();
    repeat (SYNC + 2) @(negedge clk);
  endtask

  // Vector: {is_read, addr[3:0], data[15:0], expect[15:0], req[3:0]}
  localparam int NV = 15;
  localparam logic [40:0] VECS [NV] = '{
    {1'b1, 4'hA, 16'h0000, 16'h0000, 4'd1},   // R1 counter reset
    {1'b0, 4'hA, 16'h1234, 16'h0000, 4'd2},   // R2 low load
    {1'b0, 4'hB, 16'h5603, 16'h0000, 4'd2},   // R2 high load, mode 3
    {1'b1, 4'hA, 16'h0000, 16'h1234, 4'd2},
    {1'b1, 4'hB, 16'h0000, 16'h5600, 4'd2},   // R2 low byte zero
    {1'b1, 4'h1, 16'h0000, 16'h00C8, 4'd9},   // R9 tag, enable 0
    {1'b0, 4'h1, 16'h0012, 16'h0000, 4'd9},   // R9 enable + device enable
    {1'b1, 4'h1, 16'h0000, 16'h00CC, 4'd9},
    {1'b1, 4'h3, 16'h0000, 16'h0520, 4'd12},  // R12 ident
    {1'b1, 4'h9, 16'h0000, 16'h0010, 4'd11},  // R11 ack word
    {1'b0, 4'h1, 16'h0003, 16'h0000, 4'd9},   // R9 clear wins
    {1'b1, 4'h1, 16'h0000, 16'h00C8, 4'd9},
    {1'b0, 4'hB, 16'hFF20, 16'h0000, 4'd4},   // R4 clear overrides data
    {1'b1, 4'hB, 16'h0000, 16'h0000, 4'd4},
    {1'b1, 4'hA, 16'h0000, 16'h0000, 4'd4}
  };

  initial begin
    logic [15:0] r, exp_st;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 cnt_zero", 16'(cnt_zero), 16'h1);
    check("R1 irq_req", 16'(irq_req), 16'h0);
    check("R1 hs_mode", 16'(hs_mode), 16'h0);
    check("R1 pflg_low_true", 16'(pflg_low_true), 16'h0);
    check("R1 dev_enable", 16'(dev_enable), 16'h0);
    check("R1/R6 ctl_lines option on", 16'(ctl_lines), 16'(6'b100000));
    check("R1/R7 sts_lines pass", 16'(sts_lines), 16'(ext_sts));

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][40]) begin
        rd(VECS[i][39:36], r);
        check($sformatf("R%0d vector %0d", VECS[i][3:0], i), r, VECS[i][19:4]);
      end else begin
        wr(VECS[i][39:36], VECS[i][35:20]);
      end
    end
    check("R9 dev_enable cleared", 16'(dev_enable), 16'h0);

    // R3 decrement and floor
    wr(4'hA, 16'h0003);
    check("R3 nonzero flag", 16'(cnt_zero), 16'h0);
    for (int k = 2; k >= 0; k--) begin
      pulse_xfer();
      rd(4'hA, r);
      check("R3 decrement", r, 16'(k));
    end
    check("R3 zero flag", 16'(cnt_zero), 16'h1);
    pulse_xfer();
    rd(4'hA, r);
    check("R3 floor at zero", r, 16'h0000);

    // R4 write priority over transfer pulse
    wr(4'hA, 16'h0005);
    @(negedge clk); bus_wr = 1; bus_addr = 4'hB; bus_wdata = 16'h0720; xfer_pulse = 1;
    @(negedge clk); bus_wr = 0; xfer_pulse = 0;
    rd(4'hA, r); check("R4 clear beats pulse lo", r, 16'h0000);
    rd(4'hB, r); check("R4 clear beats pulse hi", r, 16'h0000);
    @(negedge clk); bus_wr = 1; bus_addr = 4'hA; bus_wdata = 16'h0009; xfer_pulse = 1;
    @(negedge clk); bus_wr = 0; xfer_pulse = 0;
    rd(4'hA, r); check("R4 load beats pulse", r, 16'h0009);

    // R5 mode and polarity
    wr(4'hB, 16'h0005);
    check("R5 hs_mode", 16'(hs_mode), 16'h5);
    wr(4'h7, 16'h0020 | 16'h0040);
    check("R5 pflg_low_true", 16'(pflg_low_true), 16'h1);

    // R6 control lines
    wr(4'h7, 16'h0500 | 16'h0003);        // bits 10,8 set, option off
    check("R6 ctl stored", 16'(ctl_lines), 16'(6'b101011));
    hs_pdir = 0; hs_hend = 1;
    wr(4'h7, 16'h0500 | 16'h0040 | 16'h0003);
    check("R6 ctl option", 16'(ctl_lines), 16'(6'b011011));

    // R10 / R11 interrupt request
    wr(4'h1, 16'h0002);
    @(negedge clk); ext_attn = 1; settle();
    check("R10 request set", 16'(irq_req), 16'h1);
    rd(4'h1, r); check("R9 sense with request", r, 16'h00CD);
    rd(4'hA, r); check("R11 other read keeps", 16'(irq_req), 16'h1);
    rd(4'h9, r); check("R11 ack word", r, 16'h0010);
    check("R11 ack clears", 16'(irq_req), 16'h0);
    ext_attn = 0; settle();
    wr(4'h1, 16'h0001);
    ext_attn = 1; settle();
    check("R10 disabled no request", 16'(irq_req), 16'h0);
    ext_attn = 0; settle();

    // R7 / R8 / R13 status word and lines
    wr(4'h1, 16'h0002);
    wr(4'h7, 16'h0080 | 16'h0040);
    fifo_half = 1; fifo_aef = 0; hs_pctl = 1; hs_pflg = 0; fifo_or = 1; fifo_ir = 0;
    hs_hend = 1; ext_sts = 6'b010110; ext_pend = 1; ext_attn = 1;
    settle();
    check("R7 sts_lines options", 16'(sts_lines), 16'(6'b110110));
    exp_st = '0;
    exp_st[15] = 1; exp_st[14] = 0; exp_st[13] = 1; exp_st[12] = 1;
    exp_st[11] = 0; exp_st[10] = 1; exp_st[9] = 1; exp_st[8] = 0;
    exp_st[7] = 1; exp_st[6] = 0; exp_st[5] = 1; exp_st[4] = 0;
    exp_st[3] = 1; exp_st[2:0] = 3'b110;
    rd(4'h7, r); check("R8 status word", r, exp_st);
    wr(4'h1, 16'h0001);
    wr(4'h7, 16'h0040);
    check("R7 sts_lines pass", 16'(sts_lines), 16'(6'b010110));
    wr(4'hB, 16'h0010);
    rd(4'h7, r); check("R13 end latch cleared", 16'(r[13]), 16'h0);

    @(negedge clk); bus_wr = 1; bus_addr = 4'h7; bus_wdata = 16'h0050;
    @(negedge clk); bus_wr = 0;
    #1 check("R13 clear pulse high", 16'(fifo_clear), 16'h1);
    @(negedge clk);
    #1 check("R13 clear pulse one cycle", 16'(fifo_clear), 16'h0);
    @(negedge clk); bus_wr = 1; bus_addr = 4'h1; bus_wdata = 16'h0020;
    @(negedge clk); bus_wr = 0;
    #1 check("R13 device clear high", 16'(dev_clear), 16'h1);
    @(negedge clk);
    #1 check("R13 device clear one cycle", 16'(dev_clear), 16'h0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule